// File: doc/BRIEF.md
# External Memory Bus Sequencer

This block produces the timing of an 8-bit microcontroller's external memory bus. It runs on the oscillator clock, and each machine cycle lasts twelve clocks. At the last clock of a machine cycle it takes the requests that the core presents: a code fetch, or a data access that is a read or a write and has either a 16-bit or an 8-bit address. It then plays out the whole next machine cycle. During that cycle it drives the address-latch strobe, the active-low program-store, read and write strobes, the multiplexed low address/data byte with its output enable, and the high byte port.

The address-latch strobe runs free at two pulses per machine cycle. A control bit can turn it off, but only while code runs from internal memory. In that case it stays high, and it pulses only in external data cycles. An external fetch cycle gives two program-store pulses. A data cycle gives none, so the two fetch strobes that would have come are skipped. A strap input selects where code comes from. A lock input can freeze the strap value that was seen during reset.

Top module: `xbus_seq`

## Requirements
- R1: When the address-latch strobe is not suppressed, `ale` is high in phases 0-1 and 6-7 of every fetch or idle cycle. That gives two pulses per twelve clocks. Phase 0 is the first clock after the boundary at which requests are sampled.
- R2: An external fetch cycle drives `psen_n` low in phases 3-5 and 9-11. The address `addr` is on `ad_out` in phases 0-2 and `addr+1` in phases 6-8, with `ad_oe` high. `ad_oe` is low while `psen_n` is low.
- R3: A data cycle keeps `psen_n` high for all twelve clocks, even when code runs externally. `ale` is high only in phases 0-1, with the low address byte on `ad_out` in phases 0-2.
- R4: A data read drives `rd_n` low in phases 3-10 and keeps `ad_oe` low in phases 3-11. `wr_n` stays high.
- R5: A data write drives `wr_n` low in phases 3-10. It drives `wdata` on `ad_out` with `ad_oe` high in phases 3-11. `rd_n` stays high.
- R6: `hi_out` gives the high byte of the address in use. For a fetch this is the high byte of `addr` in the first half and of `addr+1` in the second. For a 16-bit data access it is `addr[15:8]`. For an 8-bit data access, and in idle or internal-fetch cycles, it is `p2_reg`.
- R7: When `ale_off` is 1 and code runs internally, `ale` stays 1 through idle and internal-fetch cycles. In data cycles it still pulses in phases 0-1.
- R8: `ale_off` has no effect while code runs externally.
- R9: `code_ext_n` low makes fetches external. When it is high, a fetch request produces no `psen_n` pulse and no bus activity. When `lock_hold` is 1, the strap value seen during reset is used and later changes of `code_ext_n` are ignored.
- R10: During reset the outputs show an idle last phase: `ale`=0, all strobes high, `ad_oe`=0, `hi_out`=0. Requests are sampled only at the last phase. If a data request and a fetch request come together, the data request wins.
- R11: `ale` is low whenever a strobe is active. In bus cycles, the low byte is stable and driven when `ale` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_req | input | 1 | Code fetch request for the next machine cycle |
| dat_req | input | 1 | Data access request for the next machine cycle |
| dat_wide | input | 1 | 1 = 16-bit data address, 0 = 8-bit |
| dat_wr | input | 1 | 1 = data write, 0 = data read |
| addr | input | 16 | Fetch or data address |
| wdata | input | 8 | Write data |
| p2_reg | input | 8 | High port register contents |
| code_ext_n | input | 1 | Strap: low selects external code memory |
| lock_hold | input | 1 | 1 = use the strap value captured in reset |
| ale_off | input | 1 | Address-latch strobe suppress request |
| ale | output | 1 | Address latch strobe, active high |
| psen_n | output | 1 | Program store strobe, active low |
| rd_n | output | 1 | Data read strobe, active low |
| wr_n | output | 1 | Data write strobe, active low |
| ad_out | output | 8 | Low address / data byte |
| ad_oe | output | 1 | Output enable for `ad_out` |
| hi_out | output | 8 | High byte port |

## Verification
On every clock, the assertions check that no two strobes are active together, that `ale` is low under any strobe, and that the low byte holds still across the falling edge of `ale`. They also check that the bus is released during a read, that write data holds steady, that an external fetch cycle contains exactly two `psen_n` falls, and that the phase counter advances in order. Some behaviours can only be shown by the bench's scenarios: the exact phase placement of every pulse, the `addr+1` carry into the high byte, the choice between `p2_reg` and the address, data winning over fetch, the suppressed-strobe modes, and the strap lock across a second reset.

// File: rtl/xbus_pkg.sv
// Shared widths and the machine-cycle descriptor for the external bus sequencer.
// Assumes a byte-wide data bus and a two-byte address.
package xbus_pkg;
    parameter int ADDR_W = 16;
    parameter int DATA_W = 8;

    typedef enum logic [1:0] {
        CYC_IDLE   = 2'd0,
        CYC_FETCH  = 2'd1,
        CYC_DREAD  = 2'd2,
        CYC_DWRITE = 2'd3
    } cyc_kind_t;

    typedef struct packed {
        cyc_kind_t           kind;
        logic                wide;
        logic                ext_code;
        logic                ale_off;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   wdata;
        logic [DATA_W-1:0]   p2;
    } cyc_desc_t;
endpackage

// File: rtl/xbus_phase.sv
// Machine-cycle phase counter. Counts 0..N_PH-1 and flags the last phase.
// Assumes N_PH is a multiple of 12 so the derived sub-windows are whole clocks.
module xbus_phase #(
    parameter int N_PH = 12,
    localparam int PH_W = $clog2(N_PH)
) (
    input  logic            clk,
    input  logic            rst_n,
    output logic [PH_W-1:0] ph,
    output logic            cyc_last
);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(N_PH - 1);

    assign cyc_last = (ph == PH_LAST);

    // Advance the phase; reset parks on the last phase so the first cycle starts cleanly.
    always_ff @(posedge clk) begin
        if (!rst_n)        ph <= PH_LAST;
        else if (cyc_last) ph <= '0;
        else               ph <= ph + 1'b1;
    end

    assert_phase_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_last |=> (ph == '0));
    assert_phase_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_last && $past(rst_n)) |=> (ph == $past(ph) + 1'b1));
endmodule

// File: rtl/xbus_capture.sv
// Samples the requests at the last phase into a descriptor held for one machine cycle.
// Also captures the code-source strap during reset for the lock option.
module xbus_capture import xbus_pkg::*; (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_last,
    input  logic              fetch_req,
    input  logic              dat_req,
    input  logic              dat_wide,
    input  logic              dat_wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] p2_reg,
    input  logic              code_ext_n,
    input  logic              lock_hold,
    input  logic              ale_off,
    output cyc_desc_t         desc
);
    logic strap_ext_q;
    logic ext_eff;

    // Capture the strap while reset is held; keep it afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) strap_ext_q <= !code_ext_n;
    end

    assign ext_eff = lock_hold ? strap_ext_q : !code_ext_n;

    // Load the next cycle's descriptor at the boundary; data wins over fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            desc <= '0;
        end else if (cyc_last) begin
            if (dat_req)        desc.kind <= dat_wr ? CYC_DWRITE : CYC_DREAD;
            else if (fetch_req) desc.kind <= CYC_FETCH;
            else                desc.kind <= CYC_IDLE;
            desc.wide     <= dat_wide;
            desc.ext_code <= ext_eff;
            desc.ale_off  <= ale_off;
            desc.addr     <= addr;
            desc.wdata    <= wdata;
            desc.p2       <= p2_reg;
        end
    end

    assert_desc_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_last && $past(rst_n)) |=> $stable(desc));
endmodule

// File: rtl/xbus_drive.sv
// Turns the phase and the cycle descriptor into bus strobes and byte lanes.
// Assumes N_PH/6 clocks of latch pulse and N_PH/4 clocks of address phase per half cycle.
module xbus_drive import xbus_pkg::*; #(
    parameter int N_PH = 12,
    localparam int PH_W = $clog2(N_PH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PH_W-1:0]   ph,
    input  cyc_desc_t         desc,
    output logic              ale,
    output logic              psen_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [DATA_W-1:0] hi_out
);
    localparam logic [PH_W-1:0] HALF    = PH_W'(N_PH / 2);
    localparam logic [PH_W-1:0] ALE_W   = PH_W'(N_PH / 6);
    localparam logic [PH_W-1:0] ADR_PH  = PH_W'(N_PH / 4);
    localparam logic [PH_W-1:0] STB_END = PH_W'(N_PH - 2);
    localparam logic [PH_W-1:0] PH_LAST = PH_W'(N_PH - 1);

    logic              second;
    logic [PH_W-1:0]   ph_h;
    logic              is_fetch;
    logic              is_data;
    logic              ale_std;
    logic [ADDR_W-1:0] fetch_addr;

    assign second     = (ph >= HALF);
    assign ph_h       = second ? (ph - HALF) : ph;
    assign is_fetch   = (desc.kind == CYC_FETCH) && desc.ext_code;
    assign is_data    = (desc.kind == CYC_DREAD) || (desc.kind == CYC_DWRITE);
    assign fetch_addr = desc.addr + ADDR_W'(second);

    // Latch strobe: two pulses per cycle, second dropped in data cycles, held high when suppressed.
    always_comb begin
        ale_std = (ph < ALE_W) || (second && (ph_h < ALE_W) && !is_data);
        if (desc.ale_off && !desc.ext_code && !is_data) ale = 1'b1;
        else                                             ale = ale_std;
    end

    // Active-low strobes in their phase windows.
    always_comb begin
        psen_n = !(is_fetch && (ph_h >= ADR_PH));
        rd_n   = !((desc.kind == CYC_DREAD)  && (ph >= ADR_PH) && (ph <= STB_END));
        wr_n   = !((desc.kind == CYC_DWRITE) && (ph >= ADR_PH) && (ph <= STB_END));
    end

    // Low byte lane: address phases, write data, released otherwise.
    always_comb begin
        ad_oe  = 1'b0;
        ad_out = '0;
        if (is_fetch) begin
            if (ph_h < ADR_PH) begin
                ad_oe  = 1'b1;
                ad_out = fetch_addr[DATA_W-1:0];
            end
        end else if (is_data) begin
            if (ph < ADR_PH) begin
                ad_oe  = 1'b1;
                ad_out = desc.addr[DATA_W-1:0];
            end else if (desc.kind == CYC_DWRITE) begin
                ad_oe  = 1'b1;
                ad_out = desc.wdata;
            end
        end
    end

    // High byte port: address or the port register.
    always_comb begin
        if (is_fetch)                hi_out = fetch_addr[ADDR_W-1:DATA_W];
        else if (is_data && desc.wide) hi_out = desc.addr[ADDR_W-1:DATA_W];
        else                         hi_out = desc.p2;
    end

    // Checker state: program-store falls seen in the current cycle.
    logic       psen_q;
    logic [1:0] psen_falls;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psen_q     <= 1'b1;
            psen_falls <= '0;
        end else begin
            psen_q <= psen_n;
            if (ph == '0)               psen_falls <= '0;
            else if (psen_q && !psen_n) psen_falls <= psen_falls + 1'b1;
        end
    end

    assert_two_psen_per_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_LAST) |-> (psen_falls == (is_fetch ? 2'd2 : 2'd0)));
    assert_psen_skipped_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> psen_n);
    assert_one_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({!psen_n, !rd_n, !wr_n}) <= 1);
    assert_read_bus_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n |-> !ad_oe);
    assert_write_data_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_n && $past(!wr_n)) |-> (ad_oe && $stable(ad_out)));
    assert_ale_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!psen_n || !rd_n || !wr_n) |-> !ale);
    assert_addr_at_ale_fall_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ale) && (is_fetch || is_data)) |-> (ad_oe && $stable(ad_out)));
endmodule

// File: rtl/xbus_seq.sv
// External memory bus sequencer top: phase counter, request capture and bus drive.
// Assumes requests are held valid through the last phase of each machine cycle.
module xbus_seq import xbus_pkg::*; #(
    parameter int N_PH = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fetch_req,
    input  logic              dat_req,
    input  logic              dat_wide,
    input  logic              dat_wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] p2_reg,
    input  logic              code_ext_n,
    input  logic              lock_hold,
    input  logic              ale_off,
    output logic              ale,
    output logic              psen_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic [DATA_W-1:0] ad_out,
    output logic              ad_oe,
    output logic [DATA_W-1:0] hi_out
);
    localparam int PH_W = $clog2(N_PH);

    logic [PH_W-1:0] ph;
    logic            cyc_last;
    cyc_desc_t       desc;

    xbus_phase #(.N_PH(N_PH)) u_phase (
        .clk(clk), .rst_n(rst_n), .ph(ph), .cyc_last(cyc_last)
    );

    xbus_capture u_capture (
        .clk(clk), .rst_n(rst_n), .cyc_last(cyc_last),
        .fetch_req(fetch_req), .dat_req(dat_req), .dat_wide(dat_wide), .dat_wr(dat_wr),
        .addr(addr), .wdata(wdata), .p2_reg(p2_reg),
        .code_ext_n(code_ext_n), .lock_hold(lock_hold), .ale_off(ale_off),
        .desc(desc)
    );

    xbus_drive #(.N_PH(N_PH)) u_drive (
        .clk(clk), .rst_n(rst_n), .ph(ph), .desc(desc),
        .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
        .ad_out(ad_out), .ad_oe(ad_oe), .hi_out(hi_out)
    );
endmodule

// File: tb/test_xbus_seq.sv
// Scoreboard bench: the driver queues twelve expected phase items per cycle, the monitor compares.
module test_xbus_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fetch_req = 1'b0, dat_req = 1'b0, dat_wide = 1'b0, dat_wr = 1'b0;
    logic [15:0] addr = '0;
    logic [7:0]  wdata = '0, p2_reg = '0;
    logic        code_ext_n = 1'b1, lock_hold = 1'b0, ale_off = 1'b0;
    logic        ale, psen_n, rd_n, wr_n, ad_oe;
    logic [7:0]  ad_out, hi_out;

    int n_checks = 0;
    int n_fails  = 0;

    always #2.5 clk = ~clk;

    xbus_seq i_xbus_seq (
        .clk(clk), .rst_n(rst_n), .fetch_req(fetch_req), .dat_req(dat_req),
        .dat_wide(dat_wide), .dat_wr(dat_wr), .addr(addr), .wdata(wdata),
        .p2_reg(p2_reg), .code_ext_n(code_ext_n), .lock_hold(lock_hold),
        .ale_off(ale_off), .ale(ale), .psen_n(psen_n), .rd_n(rd_n), .wr_n(wr_n),
        .ad_out(ad_out), .ad_oe(ad_oe), .hi_out(hi_out)
    );

    // item = {ale, psen_n, rd_n, wr_n, oe, ad[7:0], hi[7:0], req[3:0]}
    logic [24:0] exp_q[$];

    function automatic string rname(input logic [3:0] r);
        case (r)
            4'd1: return "R1";  4'd2: return "R2";  4'd3: return "R3";
            4'd4: return "R4";  4'd5: return "R5";  4'd6: return "R6";
            4'd7: return "R7";  4'd8: return "R8";  4'd9: return "R9";
            4'd10: return "R10"; default: return "R11";
        endcase
    endfunction

    // Expected bus state at phase p; kind 0 idle, 1 fetch, 2 read, 3 write.
    function automatic logic [24:0] model(input int p, input int kind, input bit ext,
            input bit aoff, input bit wide, input logic [15:0] a, input logic [7:0] wd,
            input logic [7:0] p2, input logic [3:0] req);
        bit f, d, sec;
        int q;
        logic e_ale, e_ps, e_rd, e_wr, e_oe;
        logic [7:0] e_ad, e_hi;
        logic [15:0] fa;
        f = (kind == 1) && ext;
        d = (kind >= 2);
        sec = (p >= 6);
        q = sec ? p - 6 : p;
        fa = sec ? a + 16'd1 : a;
        if (aoff && !ext && !d) e_ale = 1'b1;                      // R7
        else e_ale = (p <= 1) || (!d && (p == 6 || p == 7));      // R1, R3, R8
        e_ps = !(f && q >= 3);                                     // R2
        e_rd = !(kind == 2 && p >= 3 && p <= 10);                  // R4
        e_wr = !(kind == 3 && p >= 3 && p <= 10);                  // R5
        e_oe = 1'b0; e_ad = 8'h00;
        if (f && q <= 2) begin e_oe = 1'b1; e_ad = fa[7:0]; end
        else if (d && p <= 2) begin e_oe = 1'b1; e_ad = a[7:0]; end
        else if (kind == 3) begin e_oe = 1'b1; e_ad = wd; end
        if (f) e_hi = fa[15:8];                                    // R6
        else if (d && wide) e_hi = a[15:8];
        else e_hi = p2;
        return {e_ale, e_ps, e_rd, e_wr, e_oe, e_ad, e_hi, req};
    endfunction

    task automatic compare(input logic [24:0] e);
        logic [20:0] act;
        logic [20:0] ex;
        act = {ale, psen_n, rd_n, wr_n, ad_oe, (e[20] ? ad_out : 8'h00), hi_out};
        ex  = e[24:4];
        n_checks++;
        if (act !== ex) begin
            n_fails++;
            $display("FAIL %s: {ale,psen_n,rd_n,wr_n,oe,ad,hi} actual=%b_%b_%b_%b_%b_%h_%h expected=%b_%b_%b_%b_%b_%h_%h",
                rname(e[3:0]), act[20], act[19], act[18], act[17], act[16], act[15:8], act[7:0],
                ex[20], ex[19], ex[18], ex[17], ex[16], ex[15:8], ex[7:0]);
        end
    endtask

    // Monitor: one queued item per machine-cycle phase, sampled at the falling edge.
    always @(negedge clk) begin
        if (exp_q.size() > 0) compare(exp_q.pop_front());
    end

    // Driver: called while phase 11 is showing; presents requests and queues the next cycle.
    task automatic run_cycle(input int kind, input bit also_fetch, input bit wide,
            input logic [15:0] a, input logic [7:0] wd, input logic [7:0] p2,
            input bit aoff, input bit ext_exp, input logic [3:0] req);
        fetch_req = (kind == 1) || also_fetch;
        dat_req   = (kind >= 2);
        dat_wr    = (kind == 3);
        dat_wide  = wide;
        addr = a; wdata = wd; p2_reg = p2; ale_off = aoff;
        @(posedge clk); #1;
        for (int p = 0; p < 12; p++) exp_q.push_back(model(p, kind, ext_exp, aoff, wide, a, wd, p2, req));
        fetch_req = 1'b0; dat_req = 1'b0;
        repeat (11) @(posedge clk);
        #1;
    endtask

    task automatic reset_dut();
        @(posedge clk); #1;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        compare({1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 8'h00, 8'h00, 4'd10}); // R10 reset state
        @(posedge clk); #1;
        rst_n = 1'b1;
    endtask

    bit done = 1'b0;
    initial begin
        #100000;
        if (!done) begin
            n_fails++;
            $display("FAIL watchdog: actual=hung expected=complete");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        reset_dut();
        run_cycle(0, 0, 0, 16'h0000, 8'h00, 8'hE1, 0, 0, 4'd1);  // R1 idle, internal code
        code_ext_n = 1'b0;                                        // R9 external code
        run_cycle(1, 0, 0, 16'h12FF, 8'h00, 8'h00, 0, 1, 4'd2);  // R2 R6 carry into high byte
        run_cycle(1, 0, 0, 16'h4000, 8'h00, 8'h00, 0, 1, 4'd2);
        run_cycle(2, 0, 1, 16'hA5C3, 8'h00, 8'h11, 0, 1, 4'd4);  // R3 R4 R6 wide read
        run_cycle(3, 0, 0, 16'h0077, 8'h5A, 8'h3C, 0, 1, 4'd5);  // R5 R6 narrow write
        run_cycle(2, 1, 0, 16'h0190, 8'h00, 8'h7E, 0, 1, 4'd10); // R10 data wins over fetch
        run_cycle(1, 0, 0, 16'h2345, 8'h00, 8'h00, 1, 1, 4'd8);  // R8 ale_off ignored
        run_cycle(0, 0, 0, 16'h0000, 8'h00, 8'h42, 1, 1, 4'd8);
        code_ext_n = 1'b1;                                        // internal code
        run_cycle(0, 0, 0, 16'h0000, 8'h00, 8'h24, 1, 0, 4'd7);  // R7 held high
        run_cycle(1, 0, 0, 16'h0F0F, 8'h00, 8'h99, 1, 0, 4'd7);  // R7 R9 internal fetch
        run_cycle(2, 0, 1, 16'hBEEF, 8'h00, 8'h00, 1, 0, 4'd7);  // R7 data pulse remains
        run_cycle(3, 0, 0, 16'h00AA, 8'hC3, 8'h81, 1, 0, 4'd7);
        run_cycle(1, 0, 0, 16'h3333, 8'h00, 8'h55, 0, 0, 4'd9);  // R9 no program strobe
        lock_hold = 1'b1; code_ext_n = 1'b0;                      // R9 lock with external strap
        reset_dut();
        code_ext_n = 1'b1;                                        // change after reset ignored
        run_cycle(1, 0, 0, 16'h8001, 8'h00, 8'h00, 1, 1, 4'd9);
        run_cycle(0, 0, 0, 16'h0000, 8'h00, 8'h0F, 0, 1, 4'd1);
        @(negedge clk);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule